// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

A bank of 32 general-purpose pins behind a small memory-mapped register port. Software reads the pin levels after a two-stage synchronizer. Output data and output enable are never written as whole words. Each change goes through a pair of write-one-to-set and write-one-to-clear addresses, so several agents can update different pins without a read-modify-write.

Every pin has its own rising-edge enable and its own falling-edge enable. An enabled edge on the synchronized level latches a pending bit. Software clears pending bits by writing ones to them. A single interrupt line is raised while any pending bit is set. The register port is a single-cycle strobe. Writes take effect at the clock edge where `req_i` and `we_i` are high. Read data is combinational from the current state.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, output data, output enable, rising enables, falling enables and pending bits are all zero, so `pin_o`, `pin_oe_o` and `irq_o` are 0 and every register reads 0.
- R2: A read of offset 0x00 returns the pin levels as they were two clock edges earlier (two-flop synchronizer). Bit n is pin n.
- R3: A write to 0x14 sets the output data bits where the word has ones and leaves the other bits unchanged. `pin_o` shows the change after that edge.
- R4: A write to 0x18 clears the output data bits where the word has ones and leaves the other bits unchanged.
- R5: A write to 0x1C sets output-enable bits and a write to 0x20 clears them, in both cases only where the word has ones. Offset 0x04 reads the enable mask, which also drives `pin_oe_o`.
- R6: Offsets 0x28 (rising enables) and 0x2C (falling enables) are read/write 32-bit masks.
- R7: A 0-to-1 change of a synchronized pin sets its pending bit only if its rising enable is set. The bit is set three edges after the pin changes.
- R8: A 1-to-0 change of a synchronized pin sets its pending bit only if its falling enable is set.
- R9: A pin with both enables set becomes pending on either transition.
- R10: Offset 0x0C reads the pending bits. Writing ones there clears those bits, and zero bits leave the others pending.
- R11: `irq_o` is high exactly while at least one pending bit is set.
- R12: If an enabled edge and a clear of the same pending bit fall on the same edge, the bit stays pending.
- R13: Reads of any offset other than 0x00, 0x04, 0x0C, 0x28 and 0x2C return zero. Writes to undefined offsets change no state. `rdata_o` is zero whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| pin_i | input | 32 | Pad input levels, asynchronous |
| pin_o | output | 32 | Pad output data |
| pin_oe_o | output | 32 | Pad output enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
Register writes become visible on `pin_o`, `pin_oe_o` and in read data from the edge that samples the strobe. A pin change reaches offset 0x00 after two edges and the pending register and `irq_o` after the third. The bench model replays the pin history per clock edge to reproduce that latency. It compares the outputs half a cycle after every edge and compares read data within the low phase of the clock, before the next edge can move state. To hit the coincident case, the clear strobe is placed so that it is sampled on exactly the third edge after the pin change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    OFS_LEVEL = 8'h00,
    OFS_DIR   = 8'h04,
    OFS_PEND  = 8'h0C,
    OFS_DSET  = 8'h14,
    OFS_DCLR  = 8'h18,
    OFS_ESET  = 8'h1C,
    OFS_ECLR  = 8'h20,
    OFS_RISE  = 8'h28,
    OFS_FALL  = 8'h2C
  } reg_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[0] <= '0;
        else         chain_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_pend.sv
module gpio_edge_pend #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q, pend_q, hit;

  assign hit = (lvl_i & ~prev_q & rise_en_i) | (~lvl_i & prev_q & fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= (pend_q & ~clr_i) | hit;  // new edge wins over clear
    end

  assign pend_o = pend_q;

  p_edge_pends_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (($past(hit) & ~pend_q) == '0));
  p_clear_works_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((pend_q & $past(clr_i & ~hit)) == '0));
  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (($past(pend_q) & ~$past(clr_i) & ~pend_q) == '0));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  localparam int unsigned W = N_PINS;

  logic [W-1:0] dout_q, oe_q, rise_q, fall_q;
  logic [W-1:0] lvl, pend, clr, wd;
  logic         wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;
  assign wd = wdata_i[W-1:0];

  gpio_sync #(.W(W), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  assign clr = (wr && addr_i == OFS_PEND) ? wd : '0;

  gpio_edge_pend #(.W(W)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (lvl),
    .rise_en_i(rise_q),
    .fall_en_i(fall_q),
    .clr_i    (clr),
    .pend_o   (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      dout_q <= '0;
      oe_q   <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr) begin
      case (addr_i)
        OFS_DSET: dout_q <= dout_q | wd;
        OFS_DCLR: dout_q <= dout_q & ~wd;
        OFS_ESET: oe_q   <= oe_q | wd;
        OFS_ECLR: oe_q   <= oe_q & ~wd;
        OFS_RISE: rise_q <= wd;
        OFS_FALL: fall_q <= wd;
        default: ;
      endcase
    end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        OFS_LEVEL: rdata_o[W-1:0] = lvl;
        OFS_DIR:   rdata_o[W-1:0] = oe_q;
        OFS_PEND:  rdata_o[W-1:0] = pend;
        OFS_RISE:  rdata_o[W-1:0] = rise_q;
        OFS_FALL:  rdata_o[W-1:0] = fall_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign pin_o    = dout_q;
  assign pin_oe_o = oe_q;
  assign irq_o    = |pend;

  p_dset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_DSET) |=> ((pin_o & $past(wd)) == $past(wd)));
  p_dclr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_DCLR) |=> ((pin_o & $past(wd)) == '0));
  p_oe_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_ESET) |=> ((pin_oe_o & $past(wd)) == $past(wd)));
  p_ignored_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !(addr_i inside {OFS_DSET, OFS_DCLR, OFS_ESET, OFS_ECLR}))
      |=> ($stable(pin_o) && $stable(pin_oe_o)));
endmodule

// File: tb/tb_gpio_edge_bank.sv
module tb_gpio_edge_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  gpio_edge_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: pin history queue, newest at index 0
  logic [31:0] hist[$];
  logic [31:0] m_dout, m_oe, m_rise, m_fall, m_pend;

  initial begin
    hist = '{32'h0, 32'h0, 32'h0, 32'h0};
    m_dout = 0; m_oe = 0; m_rise = 0; m_fall = 0; m_pend = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{32'h0, 32'h0, 32'h0, 32'h0};
      m_dout = 0; m_oe = 0; m_rise = 0; m_fall = 0; m_pend = 0;
    end else begin
      logic [31:0] now_l, old_l, hits, clrs;
      hist.push_front(pin_in);
      if (hist.size() > 6) void'(hist.pop_back());
      now_l = hist[2];
      old_l = hist[3];
      hits = (now_l & ~old_l & m_rise) | (~now_l & old_l & m_fall);
      clrs = (req && we && addr == 8'h0C) ? wdata : 32'h0;
      m_pend = (m_pend & ~clrs) | hits;
      if (req && we) begin
        case (addr)
          8'h14: m_dout = m_dout | wdata;
          8'h18: m_dout = m_dout & ~wdata;
          8'h1C: m_oe   = m_oe | wdata;
          8'h20: m_oe   = m_oe & ~wdata;
          8'h28: m_rise = wdata;
          8'h2C: m_fall = wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return hist[1];
      8'h04: return m_oe;
      8'h0C: return m_pend;
      8'h28: return m_rise;
      8'h2C: return m_fall;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3/R4 pin_o", pin_out, m_dout);
      chk("R5 pin_oe_o", pin_oe, m_oe);
      chk("R11 irq_o", {31'h0, irq}, {31'h0, m_pend != 0});
      if (!req) chk("R13 idle rdata", rdata, 32'h0);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1;
    chk(tag, rdata, m_read(a));
    chk(tag, rdata, exp);
    req = 0;
  endtask

  task automatic set_pins(logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 pin_o", pin_out, 0);
    chk("R1 pin_oe_o", pin_oe, 0);
    chk("R1 irq_o", {31'h0, irq}, 0);
    rd("R1 level", 8'h00, 0);
    rd("R1 dir", 8'h04, 0);
    rd("R1 pend", 8'h0C, 0);
    rd("R1 rise", 8'h28, 0);
    rd("R1 fall", 8'h2C, 0);
    // R3 / R4 output data
    wr(8'h14, 32'h0000_00F0);
    wr(8'h14, 32'h0000_0001);
    @(negedge clk); chk("R3 set", pin_out, 32'h0000_00F1);
    wr(8'h18, 32'h0000_0030);
    @(negedge clk); chk("R4 clear", pin_out, 32'h0000_00C1);
    // R5 output enable
    wr(8'h1C, 32'hFFFF_0000);
    wr(8'h20, 32'h0F00_0000);
    rd("R5 dir", 8'h04, 32'hF0FF_0000);
    chk("R5 pin_oe_o", pin_oe, 32'hF0FF_0000);
    // R6 enables
    wr(8'h28, 32'h0000_000F);
    wr(8'h2C, 32'h0000_00F0);
    rd("R6 rise", 8'h28, 32'h0000_000F);
    rd("R6 fall", 8'h2C, 32'h0000_00F0);
    // R2 synchronized level
    set_pins(32'hA5A5_0000);
    @(negedge clk);
    rd("R2 level after 2 edges", 8'h00, 32'hA5A5_0000);
    set_pins(32'h0);
    idle(4);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd("R10 pend cleared", 8'h0C, 0);
    // R7 rising: bit0 enabled, bit8 not
    set_pins(32'h0000_0101);
    idle(4);
    rd("R7 rise pend", 8'h0C, 32'h0000_0001);
    chk("R11 irq high", {31'h0, irq}, 1);
    // R10 clear by writing one
    wr(8'h0C, 32'h0000_0001);
    rd("R10 w1c", 8'h0C, 0);
    chk("R11 irq low", {31'h0, irq}, 0);
    // R8 falling: bit0 fall disabled, bit4 fall enabled
    set_pins(32'h0000_0010);
    idle(4);
    rd("R8 no rise on bit4", 8'h0C, 0);
    set_pins(32'h0);
    idle(4);
    rd("R8 fall pend", 8'h0C, 32'h0000_0010);
    // R9 both edges on bit9
    wr(8'h28, 32'h0000_020F);
    wr(8'h2C, 32'h0000_02F0);
    set_pins(32'h0000_0200);
    idle(4);
    rd("R9 rise", 8'h0C, 32'h0000_0210);
    wr(8'h0C, 32'h0000_0200);
    rd("R10 partial clear", 8'h0C, 32'h0000_0010);
    set_pins(32'h0);
    idle(4);
    rd("R9 fall", 8'h0C, 32'h0000_0210);
    wr(8'h0C, 32'hFFFF_FFFF);
    // R12 edge and clear on the same edge
    set_pins(32'h0000_0200);
    @(posedge clk); @(posedge clk);
    wr(8'h0C, 32'h0000_0200);
    rd("R12 edge beats clear", 8'h0C, 32'h0000_0200);
    // R13 undefined offsets
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R13 pin_o unchanged", pin_out, 32'h0000_00C1);
    chk("R13 oe unchanged", pin_oe, 32'hF0FF_0000);
    rd("R13 rd 0x40", 8'h40, 0);
    rd("R13 rd 0x14", 8'h14, 0);
    rd("R13 pend kept", 8'h0C, 32'h0000_0200);
    idle(2);
    finish_run();
  end
endmodule